// File: doc/BRIEF.md
# PCM Multiframe Transmit Timebase

This block produces the multiframe timing for a serial PCM transmit path. It runs entirely on the transmit bit clock. It keeps three position counters: the bit inside a frame, the frame inside a multiframe, and a free-running multiframe number. A downstream formatter uses these counters, together with a start-of-frame strobe and a start-of-multiframe strobe, to know which bit it is handling. The block also drives a one-cycle multiframe sync pulse that leads the sample point of bit 0 of frame 0 by exactly two bit clocks. The same block captures the serial data lines on a selectable clock edge and hands them on in the rising-edge domain.

The timebase has two modes. With `float_i` high it is the timing master. It free-runs from the programmed frame length (bit clocks per frame, L) and multiframe length (frames per multiframe, M), and it ignores the external sync. With `float_i` low it follows an external multiframe sync. Every rising edge of that input, once it has passed a two-flop synchroniser and an edge register, reloads the counters. The reload is chosen so that bit 0 of frame 0 lands a programmed bit offset D plus a programmed number of whole frames F after the edge. If no further edge arrives, the timebase keeps free-running at the programmed lengths.

The configuration inputs are expected to be static while the block runs; change them under reset. The legal range is L >= 3, M >= 1, D <= L-2 and F <= M-1. The reset input is asserted asynchronously and is released synchronously to `clk_i` by the surrounding reset logic.

Top module: `pcm_mf_timebase`

## Requirements
- R1: While reset is low, and in the first cycle after its release, bit index = 0, frame index = 0, multiframe index = 0, sync output = 0, start-of-frame = 1, start-of-multiframe = 1 and serial output = 0. Assertion of reset takes effect without a clock edge.
- R2: The bit index steps by one on each clock from 0 to L-1 and then returns to 0. The start-of-frame output is 1 exactly when the bit index is 0.
- R3: The frame index steps by one when the bit index wraps, and returns from M-1 to 0. The multiframe index increments by one (modulo 2^MF_W) on the step from bit L-1 of frame M-1 to bit 0 of frame 0. The start-of-multiframe output is 1 exactly when both indices are 0.
- R4: The sync output is a one-cycle pulse. It is high in the cycle where the bit index is L-2 and the frame index is M-1, which is two cycles before the start-of-multiframe cycle, once per multiframe of L*M cycles.
- R5: With float high, the external sync input has no effect, and the counters keep stepping as in R2 and R3.
- R6: With float low, say the external sync is first seen high at rising edge n, after having been low. Then after edge n+3 the bit index is L-2-D and the frame index is M-1-F. The sync output is high in the cycle after edge n+3+D+F*L, and bit 0 of frame 0 (start-of-multiframe) falls in the cycle after edge n+5+D+F*L.
- R7: With D of 0 or 1, the sync pulse still lands two cycles ahead, inside the previous frame. With D = 0 and F = 0 it is high in the first cycle that holds the reloaded position.
- R8: Only a rising edge of the external sync reloads. Holding it high, or letting it fall, leaves the timebase free-running, so the next sync pulse comes L*M cycles after the last one.
- R9: With the edge select at 0, the serial output after rising edge k holds the serial input present just before edge k. With the edge select at 1, it holds the input present at the falling edge just before edge k.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Transmit bit clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| float_i | input | 1 | 1: free-running master, 0: follow external sync |
| smp_fall_i | input | 1 | Serial sampling edge: 0 rising, 1 falling |
| frame_len_i | input | BIT_W | Bit clocks per frame (L) |
| mf_len_i | input | FRM_W | Frames per multiframe (M) |
| bit_dly_i | input | BIT_W | Bit offset D from external sync edge |
| frm_dly_i | input | FRM_W | Whole-frame offset F after the bit offset |
| ext_msync_i | input | 1 | External multiframe sync, asynchronous |
| ser_i | input | DAT_W | Serial data lines |
| ser_o | output | DAT_W | Serial data after edge-selected capture |
| msync_o | output | 1 | Sync pulse two clocks ahead of bit 0, frame 0 |
| bit_idx_o | output | BIT_W | Current bit position in frame |
| frm_idx_o | output | FRM_W | Current frame position in multiframe |
| mf_idx_o | output | MF_W | Multiframe number, wrapping |
| sof_o | output | 1 | Start of frame (bit 0) |
| mf_start_o | output | 1 | Bit 0 of frame 0 |

## Verification
A wrong bit or frame count appears on the index outputs in the very next cycle. A slip in the wrap logic shows as a sync pulse that no longer sits two cycles ahead of start-of-multiframe, at the latest one multiframe later. A mistake in the reload position, or in the edge-detect latency, moves the sync pulse away from cycle n+3+D+F*L, so it is seen within D+F*L+3 cycles of the external edge. A stuck multiframe counter shows only at the next multiframe boundary, which is why free runs longer than 2^MF_W multiframes are used.

// File: rtl/pcm_mftb_pkg.sv
package pcm_mftb_pkg;

  // Serial capture edge choice
  typedef enum logic {
    SMP_RISE = 1'b0,
    SMP_FALL = 1'b1
  } smp_edge_e;

  // Flops in the external-sync synchroniser ahead of the edge register
  localparam int unsigned SYNC_STAGES = 2;

endpackage

// File: rtl/pcm_mftb_sync.sv
module pcm_mftb_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic async_i,
  output logic rise_o
);

  logic [STAGES-1:0] chain_q, chain_d;
  logic              last_q;
  logic              rise_q, rise_d;

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], async_i};
    rise_d  = chain_q[STAGES-1] & ~last_q;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      chain_q <= '0;
      last_q  <= 1'b0;
      rise_q  <= 1'b0;
    end else begin
      chain_q <= chain_d;
      last_q  <= chain_q[STAGES-1];
      rise_q  <= rise_d;
    end
  end

  assign rise_o = rise_q;

endmodule

// File: rtl/pcm_mftb_pos.sv
module pcm_mftb_pos #(
  parameter int unsigned BIT_W = 8,
  parameter int unsigned FRM_W = 6,
  parameter int unsigned MF_W  = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [BIT_W-1:0] len_bit_i,
  input  logic [FRM_W-1:0] len_frm_i,
  input  logic             load_i,
  input  logic [BIT_W-1:0] ld_bit_i,
  input  logic [FRM_W-1:0] ld_frm_i,
  output logic [BIT_W-1:0] bit_o,
  output logic [FRM_W-1:0] frm_o,
  output logic [MF_W-1:0]  mf_o
);

  logic [BIT_W-1:0] bit_q, bit_d;
  logic [FRM_W-1:0] frm_q, frm_d;
  logic [MF_W-1:0]  mf_q, mf_d;
  logic             bit_wrap, frm_wrap, mf_en;

  always_comb begin
    bit_wrap = (bit_q >= (len_bit_i - BIT_W'(1)));
    frm_wrap = (frm_q >= (len_frm_i - FRM_W'(1)));
    mf_en    = bit_wrap & frm_wrap & ~load_i;
    mf_d     = mf_q + MF_W'(1);
    if (load_i) begin
      bit_d = ld_bit_i;
      frm_d = ld_frm_i;
    end else if (bit_wrap) begin
      bit_d = '0;
      frm_d = frm_wrap ? '0 : frm_q + FRM_W'(1);
    end else begin
      bit_d = bit_q + BIT_W'(1);
      frm_d = frm_q;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      bit_q <= '0;
      frm_q <= '0;
      mf_q  <= '0;
    end else begin
      bit_q <= bit_d;
      frm_q <= frm_d;
      if (mf_en) mf_q <= mf_d;
    end
  end

  assign bit_o = bit_q;
  assign frm_o = frm_q;
  assign mf_o  = mf_q;

endmodule

// File: rtl/pcm_mftb_sampler.sv
module pcm_mftb_sampler
  import pcm_mftb_pkg::*;
#(
  parameter int unsigned DAT_W = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  smp_edge_e        edge_i,
  input  logic [DAT_W-1:0] dat_i,
  output logic [DAT_W-1:0] dat_o
);

  logic [DAT_W-1:0] neg_q;
  logic [DAT_W-1:0] out_q, out_d;

  // Falling-edge capture, retimed below into the rising-edge domain
  always_ff @(negedge clk_i or negedge rst_ni) begin
    if (!rst_ni) neg_q <= '0;
    else         neg_q <= dat_i;
  end

  always_comb begin
    out_d = (edge_i == SMP_FALL) ? neg_q : dat_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) out_q <= '0;
    else         out_q <= out_d;
  end

  assign dat_o = out_q;

endmodule

// File: rtl/pcm_mf_timebase.sv
module pcm_mf_timebase
  import pcm_mftb_pkg::*;
#(
  parameter int unsigned BIT_W = 8,
  parameter int unsigned FRM_W = 6,
  parameter int unsigned MF_W  = 4,
  parameter int unsigned DAT_W = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             float_i,
  input  logic             smp_fall_i,
  input  logic [BIT_W-1:0] frame_len_i,
  input  logic [FRM_W-1:0] mf_len_i,
  input  logic [BIT_W-1:0] bit_dly_i,
  input  logic [FRM_W-1:0] frm_dly_i,
  input  logic             ext_msync_i,
  input  logic [DAT_W-1:0] ser_i,
  output logic [DAT_W-1:0] ser_o,
  output logic             msync_o,
  output logic [BIT_W-1:0] bit_idx_o,
  output logic [FRM_W-1:0] frm_idx_o,
  output logic [MF_W-1:0]  mf_idx_o,
  output logic             sof_o,
  output logic             mf_start_o
);

  localparam int unsigned SYNC_N = SYNC_STAGES;

  logic             rise_w;
  logic             load_w;
  logic [BIT_W-1:0] ld_bit_w, bit_w, lead_bit_w;
  logic [FRM_W-1:0] ld_frm_w, frm_w, last_frm_w;
  logic [MF_W-1:0]  mf_w;
  smp_edge_e        edge_w;

  pcm_mftb_sync #(.STAGES(SYNC_N)) u_sync (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .async_i (ext_msync_i),
    .rise_o  (rise_w)
  );

  // Reload target: D+2 bits and F frames ahead of bit 0, frame 0
  always_comb begin
    load_w     = rise_w & ~float_i;
    lead_bit_w = frame_len_i - BIT_W'(2);
    last_frm_w = mf_len_i - FRM_W'(1);
    ld_bit_w   = lead_bit_w - bit_dly_i;
    ld_frm_w   = last_frm_w - frm_dly_i;
    edge_w     = smp_fall_i ? SMP_FALL : SMP_RISE;
  end

  pcm_mftb_pos #(.BIT_W(BIT_W), .FRM_W(FRM_W), .MF_W(MF_W)) u_pos (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .len_bit_i (frame_len_i),
    .len_frm_i (mf_len_i),
    .load_i    (load_w),
    .ld_bit_i  (ld_bit_w),
    .ld_frm_i  (ld_frm_w),
    .bit_o     (bit_w),
    .frm_o     (frm_w),
    .mf_o      (mf_w)
  );

  pcm_mftb_sampler #(.DAT_W(DAT_W)) u_smp (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .edge_i (edge_w),
    .dat_i  (ser_i),
    .dat_o  (ser_o)
  );

  always_comb begin
    msync_o    = (bit_w == lead_bit_w) && (frm_w == last_frm_w);
    sof_o      = (bit_w == '0);
    mf_start_o = (bit_w == '0) && (frm_w == '0);
    bit_idx_o  = bit_w;
    frm_idx_o  = frm_w;
    mf_idx_o   = mf_w;
  end

endmodule

// File: rtl/pcm_mf_timebase_chk.sv
module pcm_mf_timebase_chk #(
  parameter int unsigned BIT_W = 8,
  parameter int unsigned FRM_W = 6,
  parameter int unsigned MF_W  = 4
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             float_i,
  input logic [BIT_W-1:0] frame_len_i,
  input logic [FRM_W-1:0] mf_len_i,
  input logic             load_i,
  input logic [BIT_W-1:0] bit_idx_i,
  input logic [FRM_W-1:0] frm_idx_i,
  input logic [MF_W-1:0]  mf_idx_i,
  input logic             msync_i,
  input logic             mf_start_i
);

  logic [1:0] seen_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)              seen_q <= 2'd0;
    else if (seen_q != 2'd2)  seen_q <= seen_q + 2'd1;
  end

  AST_BIT_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!load_i && (bit_idx_i < (frame_len_i - BIT_W'(1))))
    |=> (bit_idx_i == BIT_W'($past(bit_idx_i) + 1'b1)))
    else $error("bit index did not step"); // R2

  AST_FRM_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!load_i && (bit_idx_i < (frame_len_i - BIT_W'(1)))) |=> $stable(frm_idx_i))
    else $error("frame index moved mid-frame"); // R3

  AST_MF_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !((bit_idx_i >= (frame_len_i - BIT_W'(1))) && (frm_idx_i >= (mf_len_i - FRM_W'(1))))
    |=> $stable(mf_idx_i))
    else $error("multiframe index moved off boundary"); // R3

  AST_MSYNC_LEADS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((seen_q == 2'd2) && mf_start_i && !$past(load_i) && !$past(load_i, 2))
    |-> $past(msync_i, 2))
    else $error("bit 0 frame 0 without sync two cycles ahead"); // R4

  AST_MSYNC_SINGLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (msync_i && !load_i) |=> !msync_i)
    else $error("sync pulse wider than one cycle"); // R4

  AST_FLOAT_FREE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (float_i && (bit_idx_i < (frame_len_i - BIT_W'(1))))
    |=> (bit_idx_i == BIT_W'($past(bit_idx_i) + 1'b1)))
    else $error("master mode disturbed"); // R5

endmodule

bind pcm_mf_timebase pcm_mf_timebase_chk #(
  .BIT_W (BIT_W),
  .FRM_W (FRM_W),
  .MF_W  (MF_W)
) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .float_i     (float_i),
  .frame_len_i (frame_len_i),
  .mf_len_i    (mf_len_i),
  .load_i      (load_w),
  .bit_idx_i   (bit_idx_o),
  .frm_idx_i   (frm_idx_o),
  .mf_idx_i    (mf_idx_o),
  .msync_i     (msync_o),
  .mf_start_i  (mf_start_o)
);

// File: tb/sim_pcm_mf_timebase.sv
`timescale 1ns/1ps
module sim_pcm_mf_timebase;

  localparam int BIT_W = 8;
  localparam int FRM_W = 6;
  localparam int MF_W  = 4;
  localparam int DAT_W = 2;

  // Aligned-mode vectors: L, M, D, F
  localparam int NVEC = 5;
  localparam int VEC [NVEC][4] = '{
    '{8, 4, 3, 1},
    '{8, 4, 0, 0},
    '{5, 3, 1, 2},
    '{6, 2, 4, 0},
    '{4, 3, 2, 2}
  };

  logic             clk, rst_n, flt, fall, ext;
  logic [BIT_W-1:0] flen, bdly, bidx;
  logic [FRM_W-1:0] mlen, fdly, fidx;
  logic [MF_W-1:0]  midx;
  logic [DAT_W-1:0] din, dout;
  logic             msync, sof, mst;

  int total = 0;
  int bad   = 0;
  int mb, mf, mm, L, M;

  pcm_mf_timebase #(.BIT_W(BIT_W), .FRM_W(FRM_W), .MF_W(MF_W), .DAT_W(DAT_W)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .float_i(flt), .smp_fall_i(fall),
    .frame_len_i(flen), .mf_len_i(mlen), .bit_dly_i(bdly), .frm_dly_i(fdly),
    .ext_msync_i(ext), .ser_i(din), .ser_o(dout), .msync_o(msync),
    .bit_idx_o(bidx), .frm_idx_o(fidx), .mf_idx_o(midx),
    .sof_o(sof), .mf_start_o(mst)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  task automatic chk(input string req, input string what, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s %s: act=%0d exp=%0d", req, what, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    #2;
  endtask

  task automatic cfg_reset(input int l, input int m, input int d, input int f, input logic fl);
    rst_n = 1'b0;
    flt  = fl;
    flen = BIT_W'(l);
    mlen = FRM_W'(m);
    bdly = BIT_W'(d);
    fdly = FRM_W'(f);
    L = l; M = m;
    step();
    step();
    rst_n = 1'b1;
    mb = 0; mf = 0; mm = 0;
  endtask

  task automatic reset_state(input string tag);
    chk("R1", {tag, " bit"},   int'(bidx),  0);
    chk("R1", {tag, " frm"},   int'(fidx),  0);
    chk("R1", {tag, " mf"},    int'(midx),  0);
    chk("R1", {tag, " msync"}, int'(msync), 0);
    chk("R1", {tag, " sof"},   int'(sof),   1);
    chk("R1", {tag, " start"}, int'(mst),   1);
  endtask

  // One free-running cycle against the bench's own position model
  task automatic fr_cycle(input bit r5_mode);
    string ra, rb, rc;
    ra = r5_mode ? "R5" : "R2";
    rb = r5_mode ? "R5" : "R3";
    rc = r5_mode ? "R5" : "R4";
    step();
    mb++;
    if (mb == L) begin
      mb = 0;
      mf++;
      if (mf == M) begin
        mf = 0;
        mm = (mm + 1) % (1 << MF_W);
      end
    end
    chk(ra, "bit",   int'(bidx),  mb);
    chk(ra, "sof",   int'(sof),   int'(mb == 0));
    chk(rb, "frm",   int'(fidx),  mf);
    chk(rb, "mf",    int'(midx),  mm);
    chk(rb, "start", int'(mst),   int'(mb == 0 && mf == 0));
    chk(rc, "msync", int'(msync), int'(mb == L - 2 && mf == M - 1));
  endtask

  initial begin
    #(500_000);
    total++;
    bad++;
    $display("FAIL watchdog: act=running exp=finished");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    rst_n = 1'b0; flt = 1'b1; fall = 1'b0; ext = 1'b0; din = '0;
    flen = '0; mlen = '0; bdly = '0; fdly = '0;

    // R1: reset values, checked before the first counting edge
    cfg_reset(5, 3, 0, 0, 1'b1);
    reset_state("after release");
    chk("R1", "ser", int'(dout), 0);

    // R2 R3 R4: master mode, long enough to wrap the multiframe index
    for (int i = 0; i < 250; i++) fr_cycle(1'b0);

    // R5: external sync toggling in master mode changes nothing
    for (int i = 0; i < 40; i++) begin
      ext = ((i % 7) < 3);
      fr_cycle(1'b1);
    end
    ext = 1'b0;

    // R1: asynchronous reset assertion mid-run
    step();
    step();
    rst_n = 1'b0;
    #1;
    reset_state("async");

    // R6 R7 R8: aligned-mode vector table
    for (int v = 0; v < NVEC; v++) begin
      int d, f, t, p;
      string rq;
      d = VEC[v][2];
      f = VEC[v][3];
      cfg_reset(VEC[v][0], VEC[v][1], d, f, 1'b0);
      ext = 1'b0;
      repeat (3) step();
      ext = 1'b1;
      t  = 4 + d + f * L;
      p  = L * M;
      rq = (d < 2) ? "R7" : "R6";
      for (int s = 1; s <= t + 2 + p; s++) begin
        step();
        if (s == t + 3) ext = 1'b0;
        if (s == 4) begin
          chk(rq, "reload bit", int'(bidx), L - 2 - d);
          chk(rq, "reload frm", int'(fidx), M - 1 - f);
        end
        if (s >= 4 && s < t) chk(rq, "early msync", int'(msync), 0);
        if (s == t)          chk(rq, "msync", int'(msync), 1);
        if (s == t + 1)      chk(rq, "msync width", int'(msync), 0);
        if (s == t + 2) begin
          chk(rq, "start", int'(mst),  1);
          chk(rq, "bit0",  int'(bidx), 0);
          chk(rq, "frm0",  int'(fidx), 0);
          chk(rq, "sof",   int'(sof),  1);
        end
        if (s > t + 2 && s < t + p) chk("R8", "no reload", int'(msync), 0);
        if (s == t + p)             chk("R8", "next msync", int'(msync), 1);
        if (s == t + p + 2)         chk("R8", "next start", int'(mst), 1);
      end
    end

    // R9: capture edge select
    for (int sel = 0; sel < 2; sel++) begin
      fall = sel[0];
      for (int pat = 0; pat < 4; pat++) begin
        logic [DAT_W-1:0] a, b;
        a = DAT_W'(pat);
        b = ~a;
        @(posedge clk);
        #2 din = a;
        #5 din = b;
        step();
        chk("R9", sel ? "falling capture" : "rising capture", int'(dout), int'(sel ? a : b));
      end
    end

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule